// File: doc/BRIEF.md
# Buffered-Compare PWM Timer

This block is an 8-bit up-counter that drives a single PWM output. The counter runs from zero up to a programmable top value and then restarts, so the output period is top plus one timer ticks. A compare value sets where the output changes level within each period. A two-bit output mode selects whether the pulse is high-leading (non-inverting) or low-leading (inverting), or whether the output is disconnected. The counter advances only on cycles where an external prescaler enable is high.

Software writes the compare value into a holding buffer. The active compare register takes the buffered value only when the counter wraps, so a write that arrives mid-period never produces a short or stretched pulse. Reading the compare address always returns the most recent write, even while it is still waiting for the next wrap. An overflow flag and a compare-match flag are set by the counter. Each flag is cleared by writing a 1 to it. Each flag drives the interrupt line only when its own enable and the global enable are both set.

Top module: `pwm_shadow_timer`

## Requirements
- R1: On each enabled tick the count (read back at address 4) increments, and on the tick after it equals top (address 1) it returns to 0, giving a period of top+1 ticks.
- R2: When `tick_en` is low the count, the active compare value and both flags' set events stay unchanged.
- R3: A compare write goes into a buffer, and the buffer is copied into the active compare value only on a counter wrap. Until that wrap, the output keeps following the previous active value.
- R4: Reading address 2 returns the last value written to address 2, whether or not that value has been latched yet.
- R5: Control bits [1:0] select the output mode. In mode 2'b10 the output is high from count 0 until the count reaches the active compare value and low from there to top. Mode 2'b11 gives the inverse level.
- R6: An active compare value of 0 holds the output constantly low in mode 2'b10, and a value equal to top holds it constantly high. Mode 2'b11 holds the opposite constant levels.
- R7: In modes 2'b00 and 2'b01 the output is held low.
- R8: Flag bit 0 at address 3 is set on every counter wrap. Flag bit 1 is set on each enabled tick after which the count equals the active compare value.
- R9: Writing a 1 to a flag bit at address 3 clears that flag. If a set event occurs in the same cycle as the clear, the flag stays set.
- R10: `irq` is high exactly when control bit 4 (global enable) is set and either flag 0 is set with control bit 2 set, or flag 1 is set with control bit 3 set.
- R11: A new top takes effect on the next tick. If the count is already above it, the counter runs on to 255, wraps to 0 and sets the overflow flag.
- R12: Reset clears the count, top, the active and buffered compare values, control and flags. The output is then low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 control, 1 top, 2 compare, 3 flags, 4 count |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | PWM output |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach from the ports are those that depend on exact timing: a flag clear that lands on the same cycle as a wrap, a compare write that is still pending across part of a period, and a top lowered beneath a running count. The bench keeps its own arithmetic model of the count. It uses this model to place writes on chosen count values: it waits until the modelled count equals top before issuing a clear, writes a new compare mid-period, and shrinks top while the count is high. It then sweeps every compare value from 0 to top+1 in every mode across several tops, with gaps in the tick enable.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_TOP   = 1;
  localparam int unsigned ADDR_CMP   = 2;
  localparam int unsigned ADDR_FLAGS = 3;
  localparam int unsigned ADDR_COUNT = 4;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_NONINV = 2'b10,
    MODE_INV    = 2'b11
  } out_mode_e;

  typedef struct packed {
    logic      gie;
    logic      cmp_ie;
    logic      ovf_ie;
    out_mode_e mode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [CW-1:0] top,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d,
  output logic          wrap
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  always_comb begin
    wrap  = tick_en && ((cnt_q == top) || (cnt_q == CNT_MAX));
    cnt_d = cnt_q;
    if (tick_en) begin
      if (wrap) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_d;
  end

  // R1: restart after top
  a_r1_wrap_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_q == top) |=> (cnt_q == '0));
  // R2: idle without enable
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
  // R11: count past a lowered top
  a_r11_run_past_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt_q > top && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwmt_cmp_buf.sv
module pwmt_cmp_buf #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          latch,
  output logic [CW-1:0] buf_q,
  output logic [CW-1:0] act_q,
  output logic [CW-1:0] act_d
);
  logic [CW-1:0] buf_d;

  always_comb begin
    buf_d = wr_en ? wr_data : buf_q;
    act_d = latch ? buf_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_en) buf_q <= buf_d;
      if (latch) act_q <= act_d;
    end
  end

  // R3: active value moves only at a wrap
  a_r3_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(act_q));
  a_r3_take_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> (act_q == $past(buf_q)));
  // R4: buffer shows newest write
  a_r4_buffer_newest: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (buf_q == $past(wr_data)));
endmodule

// File: rtl/pwmt_wave.sv
module pwmt_wave
  import pwmt_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  out_mode_e     mode,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic [CW-1:0] top,
  output logic          pwm_q
);
  logic base;
  logic pwm_d;

  always_comb begin
    if (cmp == '0)       base = 1'b0;
    else if (cmp == top) base = 1'b1;
    else                 base = (cnt < cmp);
    unique case (mode)
      MODE_NONINV: pwm_d = base;
      MODE_INV:    pwm_d = ~base;
      default:     pwm_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_d;
  end

  // R7: disconnected modes drive low
  a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |=> !pwm_q);
  // R6: zero compare is constant
  a_r6_zero_noninv_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NONINV && cmp == '0) |=> !pwm_q);
  a_r6_zero_inv_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_INV && cmp == '0) |=> pwm_q);
endmodule

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer
  import pwmt_pkg::*;
#(
  parameter int unsigned CW = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          pwm_out,
  output logic          irq
);
  ctrl_t         ctrl_q, ctrl_d;
  logic [CW-1:0] top_q, top_d;
  logic          ovf_q, ovf_d, cmpf_q, cmpf_d;
  logic          wr_ctrl, wr_top, wr_cmp, wr_flags;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;
  logic [CW-1:0] buf_q, act_q, act_d;
  logic          cmp_hit;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == AW'(ADDR_CTRL));
    wr_top   = bus_wr && (bus_addr == AW'(ADDR_TOP));
    wr_cmp   = bus_wr && (bus_addr == AW'(ADDR_CMP));
    wr_flags = bus_wr && (bus_addr == AW'(ADDR_FLAGS));
  end

  pwmt_counter #(.CW(CW)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .top(top_q),
    .cnt_q(cnt_q), .cnt_d(cnt_d), .wrap(wrap)
  );

  pwmt_cmp_buf #(.CW(CW)) u_cmp_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmp), .wr_data(bus_wdata),
    .latch(wrap), .buf_q(buf_q), .act_q(act_q), .act_d(act_d)
  );

  // next-state for control, top and flags
  always_comb begin
    ctrl_d  = wr_ctrl ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : ctrl_q;
    top_d   = wr_top ? bus_wdata : top_q;
    cmp_hit = tick_en && (cnt_d == act_d);
    ovf_d   = wrap    | (ovf_q  & ~(wr_flags & bus_wdata[0]));
    cmpf_d  = cmp_hit | (cmpf_q & ~(wr_flags & bus_wdata[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      top_q  <= '0;
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_top)  top_q  <= top_d;
      ovf_q  <= ovf_d;
      cmpf_q <= cmpf_d;
    end
  end

  pwmt_wave #(.CW(CW)) u_wave (
    .clk(clk), .rst_n(rst_n), .mode(ctrl_d.mode), .cnt(cnt_d),
    .cmp(act_d), .top(top_d), .pwm_q(pwm_out)
  );

  always_comb begin
    irq = ctrl_q.gie & ((ovf_q & ctrl_q.ovf_ie) | (cmpf_q & ctrl_q.cmp_ie));
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(ADDR_CTRL):  bus_rdata[CTRL_W-1:0] = ctrl_q;
      AW'(ADDR_TOP):   bus_rdata = top_q;
      AW'(ADDR_CMP):   bus_rdata = buf_q;
      AW'(ADDR_FLAGS): bus_rdata[1:0] = {cmpf_q, ovf_q};
      AW'(ADDR_COUNT): bus_rdata = cnt_q;
      default:         bus_rdata = '0;
    endcase
  end

  // R8: wrap raises overflow flag
  a_r8_ovf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_q);
  // R9: clear without a competing set
  a_r9_clear_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && bus_wdata[0] && !wrap) |=> !ovf_q);
  // R10: global gate
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.gie |-> !irq);
  // R2: no set events without enable
  a_r2_no_ovf_set_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ovf_q) |=> !ovf_q);
endmodule

// File: tb/tb_pwm_shadow_timer.sv
module tb_pwm_shadow_timer;
  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       pwm_out;
  logic       irq;

  int vectors;
  int miscompares;

  pwm_shadow_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // bench model
  logic [7:0] m_cnt, m_top, m_act, m_buf;
  logic [1:0] m_mode;
  logic       m_oie, m_cie, m_gie, m_ovf, m_cmpf;

  function automatic logic exp_pwm(logic [1:0] md, logic [7:0] c, logic [7:0] cp, logic [7:0] tp);
    logic b;
    if (cp == 8'd0)      b = 1'b0;
    else if (cp == tp)   b = 1'b1;
    else                 b = (c < cp);
    if (md == 2'b10)      return b;
    else if (md == 2'b11) return ~b;
    else                  return 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [7:0] d;
    chk(req, "pwm_out", {7'd0, pwm_out}, {7'd0, exp_pwm(m_mode, m_cnt, m_act, m_top)});
    chk("R10", "irq", {7'd0, irq}, {7'd0, m_gie & ((m_ovf & m_oie) | (m_cmpf & m_cie))});
    rd(3'd4, d);
    chk("R1", "count", d, m_cnt);
    rd(3'd3, d);
    chk("R8", "flags", d, {6'd0, m_cmpf, m_ovf});
  endtask

  // one clock with given inputs, model update, then sample at negedge
  task automatic cyc(input logic tk, input logic wr, input logic [2:0] a, input logic [7:0] dat);
    logic       wrp;
    logic [7:0] ncnt, nact;
    tick_en = tk; bus_wr = wr; bus_addr = a; bus_wdata = dat;
    @(posedge clk);
    wrp  = tk && (m_cnt == m_top || m_cnt == 8'hFF);
    ncnt = tk ? (wrp ? 8'd0 : m_cnt + 8'd1) : m_cnt;
    nact = wrp ? m_buf : m_act;
    if (wr && a == 3'd2) m_buf = dat;
    if (wr && a == 3'd1) m_top = dat;
    if (wr && a == 3'd0) begin
      m_mode = dat[1:0]; m_oie = dat[2]; m_cie = dat[3]; m_gie = dat[4];
    end
    m_ovf  = wrp | (m_ovf & ~(wr && a == 3'd3 && dat[0]));
    m_cmpf = (tk && ncnt == nact) | (m_cmpf & ~(wr && a == 3'd3 && dat[1]));
    m_cnt = ncnt;
    m_act = nact;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int tops[4];
    tops = '{1, 3, 4, 7};
    vectors = 0; miscompares = 0;
    tick_en = 1'b0; bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'd0;
    m_cnt = 0; m_top = 0; m_act = 0; m_buf = 0; m_mode = 0;
    m_oie = 0; m_cie = 0; m_gie = 0; m_ovf = 0; m_cmpf = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12: reset values
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R12", "reset register", d, 8'd0);
    end
    chk("R12", "reset pwm", {7'd0, pwm_out}, 8'd0);
    chk("R12", "reset irq", {7'd0, irq}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: tops x modes x compare values, gapped ticks (R1 R2 R3 R5 R6 R7 R8)
    foreach (tops[ti]) begin
      for (int md = 0; md < 4; md++) begin
        for (int cv = 0; cv <= tops[ti] + 1; cv++) begin
          cyc(1'b0, 1'b1, 3'd0, 8'(md));
          cyc(1'b0, 1'b1, 3'd1, 8'(tops[ti]));
          cyc(1'b0, 1'b1, 3'd2, 8'(cv));
          rd(3'd2, d);
          chk("R4", "compare readback", d, 8'(cv));
          for (int k = 0; k < 3 * (tops[ti] + 2) + 2; k++) begin
            cyc((k % 3) != 2, 1'b0, 3'd0, 8'd0);
            if (md >= 2) check_all((cv == 0 || cv == tops[ti]) ? "R6" : "R5");
            else         check_all("R7");
          end
          // R2: idle cycles leave the count alone
          cyc(1'b0, 1'b0, 3'd0, 8'd0);
          check_all("R2");
        end
      end
    end

    // R3/R4: write pending mid-period, output keeps the old value
    cyc(1'b0, 1'b1, 3'd0, 8'h02);
    cyc(1'b0, 1'b1, 3'd1, 8'd9);
    cyc(1'b0, 1'b1, 3'd2, 8'd3);
    while (m_cnt != 8'd9) cyc(1'b1, 1'b0, 3'd0, 8'd0);
    cyc(1'b1, 1'b0, 3'd0, 8'd0);
    cyc(1'b1, 1'b0, 3'd0, 8'd0);
    cyc(1'b0, 1'b1, 3'd2, 8'd7);
    rd(3'd2, d);
    chk("R4", "pending readback", d, 8'd7);
    for (int k = 0; k < 25; k++) begin
      cyc(1'b1, 1'b0, 3'd0, 8'd0);
      check_all("R3");
    end

    // R9: clear on the wrap cycle loses, plain clear wins
    while (m_cnt != m_top) cyc(1'b1, 1'b0, 3'd0, 8'd0);
    cyc(1'b1, 1'b1, 3'd3, 8'h01);
    rd(3'd3, d);
    chk("R9", "set beats clear", {7'd0, d[0]}, 8'd1);
    cyc(1'b0, 1'b1, 3'd3, 8'h03);
    rd(3'd3, d);
    chk("R9", "write-one clear", d, 8'd0);

    // R10: enable combinations with flags set and clear
    for (int e = 0; e < 8; e++) begin
      cyc(1'b0, 1'b1, 3'd0, 8'(2 | (e << 2)));
      check_all("R10");
      while (m_cnt != m_top) cyc(1'b1, 1'b0, 3'd0, 8'd0);
      cyc(1'b1, 1'b0, 3'd0, 8'd0);
      check_all("R10");
      for (int k = 0; k < 4; k++) begin
        cyc(1'b1, 1'b0, 3'd0, 8'd0);
        check_all("R10");
      end
      cyc(1'b0, 1'b1, 3'd3, 8'h02);
      check_all("R10");
      cyc(1'b0, 1'b1, 3'd3, 8'h01);
      check_all("R10");
    end

    // R11: lower top below a running count
    cyc(1'b0, 1'b1, 3'd0, 8'h02);
    cyc(1'b0, 1'b1, 3'd1, 8'd200);
    while (m_cnt != 8'd150) cyc(1'b1, 1'b0, 3'd0, 8'd0);
    cyc(1'b0, 1'b1, 3'd3, 8'h03);
    cyc(1'b0, 1'b1, 3'd1, 8'd20);
    for (int k = 0; k < 140; k++) begin
      cyc(1'b1, 1'b0, 3'd0, 8'd0);
      check_all("R11");
    end
    rd(3'd3, d);
    chk("R11", "overflow after 255", {7'd0, d[0]}, 8'd1);

    // R12: asynchronous reset mid-run
    rst_n = 1'b0;
    #2;
    rd(3'd4, d);
    chk("R12", "count after reset", d, 8'd0);
    rd(3'd2, d);
    chk("R12", "compare after reset", d, 8'd0);
    chk("R12", "pwm after reset", {7'd0, pwm_out}, 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule